// File: doc/BRIEF.md
# Dual Latch/Register Bus Transceiver

This block carries 18-bit data both ways between an A side and a B side. It holds two copies that run independently of each other. Each copy has one A-to-B path and one B-to-A path, and each path has its own four controls. Every path contains one storage element. A high latch-open control turns that element into a transparent latch. When the latch is closed, the element acts as an edge-triggered register. It captures on a rising edge of the path's own strobe, but only while the path's active-low strobe enable is low. An active-low output enable selects whether the destination side is driven or released.

The block runs on a single system clock and never uses a path strobe as a clock. Each path strobe is sampled once per system clock, and a rising edge means the strobe was sampled low and is now high. In transparent mode the output follows the input with no register in the way. Tri-state pins are not modelled as inout nets. Each side has an input vector, an output vector and a per-bit drive-enable vector, and a drive-enable bit of 1 means the bit is driven.

Top module: `dual_latreg_xcvr`

## Requirements
- R1: When a path's active-low output enable is 1, every drive-enable bit of that path's destination side is 0, whatever the other controls are. When it is 0, all of those bits are 1.
- R2: When a path's latch-open control is 1, the destination output equals the source input in the same cycle. The strobe and the strobe enable have no effect on it.
- R3: When latch-open is 0 and the strobe enable is 0, a strobe that was sampled 0 at one system clock edge and is 1 at the next edge loads the source input at that edge. The output shows the loaded value from that edge onward.
- R4: When latch-open is 0 and the strobe enable is 1, a rising strobe does not change the stored value.
- R5: When latch-open is 0 and the strobe is held steady, the stored value is kept. This includes a strobe that was already high when latch-open fell, because that is not counted as an edge.
- R6: After latch-open falls, the stored value equals the source input present at the last system clock edge while latch-open was still 1.
- R7: The stored value does not depend on the output enable. A path loads while its outputs are released, and the loaded value appears once the enable returns low.
- R8: The four paths are independent. Controls and data on one path never change the output of another path.
- R9: When the synchronous active-high reset is 1 at a system clock edge, every stored value becomes zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | 36 | A-side data, copy c at bits c*18 +: 18 |
| a_out | output | 36 | A-side data driven by the B-to-A paths |
| a_drv | output | 36 | A-side per-bit drive enable |
| b_in | input | 36 | B-side data, copy c at bits c*18 +: 18 |
| b_out | output | 36 | B-side data driven by the A-to-B paths |
| b_drv | output | 36 | B-side per-bit drive enable |
| ab_oe_n | input | 2 | A-to-B output enable per copy, active low |
| ab_le | input | 2 | A-to-B latch-open per copy |
| ab_ck | input | 2 | A-to-B load strobe per copy |
| ab_ce_n | input | 2 | A-to-B strobe enable per copy, active low |
| ba_oe_n | input | 2 | B-to-A output enable per copy, active low |
| ba_le | input | 2 | B-to-A latch-open per copy |
| ba_ck | input | 2 | B-to-A load strobe per copy |
| ba_ce_n | input | 2 | B-to-A strobe enable per copy, active low |

## Verification
On every cycle the assertions check the following: outputs are released, transparent outputs follow their inputs, qualified strobe edges load the input, inhibited or steady strobes leave storage unchanged, an open latch tracks its input, and reset clears storage. Other behaviour needs a sequence of stimulus, so only the bench scenarios can show it. These scenarios cover a latch closing on the last value it passed, a strobe already high when the latch closes, data loaded while outputs float and then appearing when they are enabled, and one path's activity leaving the other three paths untouched. A behavioural reference model compares every output and drive-enable bit on every cycle, including under random control patterns.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Control bundle for one direction of one copy.
  typedef struct packed {
    logic oe_n;  // output enable, active low
    logic le;    // latch open (transparent when 1)
    logic ck;    // load strobe, sampled on the system clock
    logic ce_n;  // strobe enable, active low
  } path_ctl_t;

  localparam int unsigned DIRS = 2;  // index 0: A to B, index 1: B to A

endpackage

// File: rtl/xcvr_edge.sv
module xcvr_edge (
  input  logic clk,
  input  logic lvl,
  output logic rise
);

  logic lvl_q;

  // The previous sample is loaded on every edge, reset included, so a strobe
  // that is already high when reset ends does not look like a fresh edge.
  always_ff @(posedge clk) begin
    lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;

endmodule

// File: rtl/xcvr_store.sv
module xcvr_store
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  path_ctl_t        ctl,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [W-1:0]     drv
);

  logic         rise;
  logic         take;
  logic [W-1:0] held;

  xcvr_edge u_edge (
    .clk  (clk),
    .lvl  (ctl.ck),
    .rise (rise)
  );

  // An open latch loads on every edge and overrides the strobe gating.
  assign take = ctl.le | (~ctl.ce_n & rise);

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '0;
    end else if (take) begin
      held <= din;
    end
  end

  assign dout = ctl.le ? din : held;
  assign drv  = {W{~ctl.oe_n}};

  // R9: reset leaves storage at zero
  a_r9_reset_clears : assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> held == '0);

  // R3: qualified strobe edge loads the input
  a_r3_edge_loads : assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!ctl.le && !ctl.ce_n && rise)) |-> held == $past(din));

  // R4: disabled strobe leaves storage unchanged
  a_r4_inhibit_holds : assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!ctl.le && ctl.ce_n)) |-> $stable(held));

  // R5: no edge while closed keeps the value
  a_r5_steady_holds : assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!ctl.le && !rise)) |-> $stable(held));

  // R6: open latch tracks input, so it closes on the last value passed
  a_r6_open_tracks : assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl.le)) |-> held == $past(din));

endmodule

// File: rtl/xcvr_channel.sv
module xcvr_channel
  import xcvr_pkg::*;
#(
  parameter int unsigned W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  path_ctl_t        ab_ctl,
  input  path_ctl_t        ba_ctl,
  input  logic [W-1:0]     a_in,
  input  logic [W-1:0]     b_in,
  output logic [W-1:0]     a_out,
  output logic [W-1:0]     a_drv,
  output logic [W-1:0]     b_out,
  output logic [W-1:0]     b_drv
);

  path_ctl_t    ctl  [DIRS];
  logic [W-1:0] src  [DIRS];
  logic [W-1:0] dst  [DIRS];
  logic [W-1:0] den  [DIRS];

  assign ctl[0] = ab_ctl;
  assign ctl[1] = ba_ctl;
  assign src[0] = a_in;
  assign src[1] = b_in;

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    xcvr_store #(.W(W)) u_store (
      .clk  (clk),
      .rst  (rst),
      .ctl  (ctl[d]),
      .din  (src[d]),
      .dout (dst[d]),
      .drv  (den[d])
    );

    // R1: a high output enable releases the destination side
    a_r1_release : assert property (@(posedge clk) disable iff (rst)
      ctl[d].oe_n |-> den[d] == '0);

    // R2: an open latch passes the input straight through
    a_r2_transparent : assert property (@(posedge clk) disable iff (rst)
      ctl[d].le |-> dst[d] == src[d]);
  end

  assign b_out = dst[0];
  assign b_drv = den[0];
  assign a_out = dst[1];
  assign a_drv = den[1];

endmodule

// File: rtl/dual_latreg_xcvr.sv
module dual_latreg_xcvr
  import xcvr_pkg::*;
#(
  parameter int unsigned W  = 18,
  parameter int unsigned NC = 2,
  localparam int unsigned BW = W * NC
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] a_in,
  output logic [BW-1:0] a_out,
  output logic [BW-1:0] a_drv,
  input  logic [BW-1:0] b_in,
  output logic [BW-1:0] b_out,
  output logic [BW-1:0] b_drv,
  input  logic [NC-1:0] ab_oe_n,
  input  logic [NC-1:0] ab_le,
  input  logic [NC-1:0] ab_ck,
  input  logic [NC-1:0] ab_ce_n,
  input  logic [NC-1:0] ba_oe_n,
  input  logic [NC-1:0] ba_le,
  input  logic [NC-1:0] ba_ck,
  input  logic [NC-1:0] ba_ce_n
);

  for (genvar c = 0; c < NC; c++) begin : g_copy
    path_ctl_t ab_ctl;
    path_ctl_t ba_ctl;

    assign ab_ctl = '{oe_n: ab_oe_n[c], le: ab_le[c], ck: ab_ck[c], ce_n: ab_ce_n[c]};
    assign ba_ctl = '{oe_n: ba_oe_n[c], le: ba_le[c], ck: ba_ck[c], ce_n: ba_ce_n[c]};

    xcvr_channel #(.W(W)) u_chan (
      .clk    (clk),
      .rst    (rst),
      .ab_ctl (ab_ctl),
      .ba_ctl (ba_ctl),
      .a_in   (a_in[c*W +: W]),
      .b_in   (b_in[c*W +: W]),
      .a_out  (a_out[c*W +: W]),
      .a_drv  (a_drv[c*W +: W]),
      .b_out  (b_out[c*W +: W]),
      .b_drv  (b_drv[c*W +: W])
    );
  end

endmodule

// File: tb/sim_dual_latreg_xcvr.sv
module sim_dual_latreg_xcvr;

  localparam int W  = 18;
  localparam int NC = 2;
  localparam int NP = NC * 2;  // path p = copy*2 + dir, dir 0 is A to B
  localparam int BW = W * NC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [BW-1:0] a_in, a_out, a_drv, b_in, b_out, b_drv;
  logic [NC-1:0] ab_oe_n, ab_le, ab_ck, ab_ce_n, ba_oe_n, ba_le, ba_ck, ba_ce_n;

  logic [W-1:0] src [NP];
  logic oe_n [NP], le [NP], ck [NP], ce_n [NP];

  int total = 0;
  int bad   = 0;

  always_comb begin
    for (int c = 0; c < NC; c++) begin
      a_in[c*W +: W] = src[c*2];
      b_in[c*W +: W] = src[c*2+1];
      ab_oe_n[c] = oe_n[c*2];   ba_oe_n[c] = oe_n[c*2+1];
      ab_le[c]   = le[c*2];     ba_le[c]   = le[c*2+1];
      ab_ck[c]   = ck[c*2];     ba_ck[c]   = ck[c*2+1];
      ab_ce_n[c] = ce_n[c*2];   ba_ce_n[c] = ce_n[c*2+1];
    end
  end

  dual_latreg_xcvr #(.W(W), .NC(NC)) u0 (
    .clk(clk), .rst(rst),
    .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_ck(ab_ck), .ab_ce_n(ab_ce_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ck(ba_ck), .ba_ce_n(ba_ce_n)
  );

  // Behavioural reference: stored word, last strobe sample, reason for last update
  logic [W-1:0] m_st   [NP];
  logic         m_prev [NP];
  string        m_why  [NP];

  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (rst) begin
        m_st[p] = '0; m_why[p] = "R9";
      end else if (le[p]) begin
        m_st[p] = src[p]; m_why[p] = "R6";
      end else if (ck[p] && !m_prev[p]) begin
        if (!ce_n[p]) begin m_st[p] = src[p]; m_why[p] = "R3"; end
        else m_why[p] = "R4";
      end else begin
        m_why[p] = "R5";
      end
      m_prev[p] = ck[p];
    end
  end

  function automatic logic [W-1:0] got_out(int p);
    return (p % 2 == 0) ? b_out[(p/2)*W +: W] : a_out[(p/2)*W +: W];
  endfunction

  function automatic logic [W-1:0] got_drv(int p);
    return (p % 2 == 0) ? b_drv[(p/2)*W +: W] : a_drv[(p/2)*W +: W];
  endfunction

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_all();
    for (int p = 0; p < NP; p++) begin
      chk("R1 drive", got_drv(p), {W{~oe_n[p]}});
      if (le[p]) chk("R2 pass", got_out(p), src[p]);
      else       chk(m_why[p], got_out(p), m_st[p]);
    end
  endtask

  // Check with current inputs, then advance one system clock.
  task automatic tick();
    #1;
    check_all();
    @(posedge clk);
    #2;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < NP; p++) begin
      src[p] = 18'h3FFFF; oe_n[p] = 1'b0; le[p] = 1'b0; ck[p] = 1'b0; ce_n[p] = 1'b0;
    end
    rst = 1'b1;
    repeat (3) begin @(posedge clk); #2; end
    rst = 1'b0;
    #1;
    chk("R9 reset", b_out[0 +: W], 18'h0);
    tick();

    // R2: transparent, strobe and enable toggling have no effect
    le[0] = 1'b1; src[0] = 18'h2AAAA; ce_n[0] = 1'b1; #1;
    chk("R2 pass", b_out[0 +: W], 18'h2AAAA);
    tick();
    ck[0] = 1'b1; ce_n[0] = 1'b0; src[0] = 18'h12345; #1;
    chk("R2 ignore strobe", b_out[0 +: W], 18'h12345);
    tick();

    // R6: close latch, then change input
    le[0] = 1'b0; ck[0] = 1'b0; src[0] = 18'h3FFFF; #1;
    chk("R6 close", b_out[0 +: W], 18'h12345);
    tick();

    // R4: edge while enable high
    ce_n[0] = 1'b1; ck[0] = 1'b1; src[0] = 18'h00001;
    tick(); #1;
    chk("R4 inhibit", b_out[0 +: W], 18'h12345);
    ck[0] = 1'b0; ce_n[0] = 1'b0;
    tick();

    // R3: enabled rising edge loads
    ck[0] = 1'b1; src[0] = 18'h0F0F0;
    tick(); src[0] = 18'h11111; #1;
    chk("R3 load", b_out[0 +: W], 18'h0F0F0);
    tick();

    // R5: strobe already high while latch closes
    le[0] = 1'b1; src[0] = 18'h2BCDE;
    tick();
    le[0] = 1'b0; src[0] = 18'h15555;
    tick(); tick(); #1;
    chk("R5 high hold", b_out[0 +: W], 18'h2BCDE);
    ck[0] = 1'b0;
    tick(); #1;
    chk("R5 low hold", b_out[0 +: W], 18'h2BCDE);

    // R7 and R1: load while released, then enable
    oe_n[0] = 1'b1; le[0] = 1'b1; src[0] = 18'h0ABCD;
    tick();
    le[0] = 1'b0; src[0] = 18'h0; #1;
    chk("R1 released", b_drv[0 +: W], 18'h0);
    tick();
    oe_n[0] = 1'b0; #1;
    chk("R7 stored", b_out[0 +: W], 18'h0ABCD);
    chk("R1 driven", b_drv[0 +: W], 18'h3FFFF);

    // R8: busy copy1 B-to-A leaves the other paths alone
    le[3] = 1'b1; src[3] = 18'h3C3C3; ck[3] = 1'b1;
    tick(); tick(); #1;
    chk("R8 copy1 ba", a_out[W +: W], 18'h3C3C3);
    chk("R8 copy0 ab", b_out[0 +: W], 18'h0ABCD);
    chk("R8 copy1 ab", b_out[W +: W], 18'h0);
    chk("R8 copy0 ba", a_out[0 +: W], 18'h0);

    // Random control patterns, model compared every cycle
    for (int n = 0; n < 600; n++) begin
      for (int p = 0; p < NP; p++) begin
        src[p]  = W'($urandom);
        oe_n[p] = ($urandom % 4) == 0;
        le[p]   = ($urandom % 5) == 0;
        ck[p]   = $urandom % 2;
        ce_n[p] = ($urandom % 3) == 0;
      end
      tick();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule